// File: doc/BRIEF.md
# Buffered SPI Master Transmit Engine

This block serialises bytes onto a SPI data line as a bus master. A free-running counter divides the bus clock by 2, 8, 32 or 128, and every bit slot of the serial clock is aligned to that counter. A write port loads a one-byte holding buffer. A holding buffer that is separate from the shift register lets software place the next byte while the current one is still going out.

A write does not start a transfer directly. The holding buffer is moved into the shift register at the next boundary of the divided clock, so the start delay is between one bus cycle and one full bit time. When a byte is waiting as the eighth bit of the current byte ends, the waiting byte follows with no idle slot. Clock polarity and clock phase can be selected. Data leaves most significant bit first.

Top module: `spi_tx_master`

## Requirements
- R1: `div_sel_i` picks the serial bit time in bus cycles: 0 gives 2, 1 gives 8, 2 gives 32 and 3 gives 128. Bit slots follow a divider that runs freely from reset.
- R2: A transfer begins only at a divider slot boundary. Between the clock edge that accepts a write to an idle engine and the edge that raises `busy_o`, there are between 1 and that ratio bus cycles.
- R3: Each byte is sent as 8 bits, most significant first. `mosi_o` changes only at slot boundaries.
- R4: With `cpha_i`=0, `mosi_o` carries each bit for half a slot before the first `sck_o` edge of that slot. The receiver samples on the first edge of the slot, which falls at the middle of the slot.
- R5: With `cpha_i`=1, the first `sck_o` edge of a slot occurs together with the new bit at the slot boundary. The receiver samples on the second edge, which falls at the middle of the slot.
- R6: `tx_empty_o` is 1 after reset. An accepted write clears it on the next edge. It returns to 1 on the edge where the held byte moves into the shift register.
- R7: When a byte is held as the eighth bit ends, it starts in the very next slot. `busy_o` stays high across the boundary.
- R8: A write while `tx_empty_o` is 0 is discarded, so the held byte is not changed. It sets `wr_err_o`, which then stays 1 until reset.
- R9: While `busy_o` is 0, `sck_o` equals `cpol_i` and `mosi_o` is 0.
- R10: During reset, `busy_o`=0, `tx_empty_o`=1, `wr_err_o`=0, `mosi_o`=0 and `sck_o`=`cpol_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_sel_i | input | 2 | Divide ratio select (2/8/32/128) |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Clock phase select |
| wr_en_i | input | 1 | Write strobe for the transmit buffer |
| wr_data_i | input | 8 | Byte to queue |
| tx_empty_o | output | 1 | Buffer can accept a byte |
| wr_err_o | output | 1 | Sticky flag for a write to a full buffer |
| busy_o | output | 1 | Transfer in progress |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |

## Verification
A wrong divider phase shifts every `sck_o` edge, so the error is visible within one bit time of reset. A shift register or bit counter that slips corrupts `mosi_o` at the next slot boundary and puts the byte-end edge of `busy_o` in the wrong cycle. A buffer flag that is lost or gets stuck shows up on `tx_empty_o` on the edge after the write or the transfer. If the flag hides a held byte, the next back-to-back start does not happen. The reference model predicts every output on every cycle, so a divergence is reported in the cycle where it first appears.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned DIV_SEL_W = 2;
  // ratio = 2^(1 + 2*sel): 2, 8, 32, 128
  localparam int unsigned CNT_W     = 1 + 2 * ((1 << DIV_SEL_W) - 1);
  localparam int unsigned BIT_W     = $clog2(DATA_W);

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/spi_tx_clkdiv.sv
module spi_tx_clkdiv
  import spi_tx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  output logic                 lead_o,
  output logic                 mid_o
);
  localparam int unsigned RATIO_W = CNT_W + 1;

  cnt_t                 cnt_q;
  logic [RATIO_W-1:0]   ratio;
  cnt_t                 term;
  cnt_t                 half_m1;

  always_comb begin
    ratio   = RATIO_W'(1) << (1 + 2 * div_sel_i);
    term    = cnt_t'(ratio - RATIO_W'(1));
    half_m1 = cnt_t'((ratio >> 1) - RATIO_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q >= term)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + cnt_t'(1);
  end

  assign lead_o = (cnt_q == term);
  assign mid_o  = (cnt_q == half_m1);

  // a ratio shrunk under the counter must wrap at once
  assert_cnt_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q > term) |=> (cnt_q == '0));
  assert_lead_mid_apart_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && mid_o));
endmodule

// File: rtl/spi_tx_buf.sv
module spi_tx_buf
  import spi_tx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  data_t wr_data_i,
  input  logic  take_i,
  output logic  full_o,
  output data_t data_o,
  output logic  err_o
);
  logic  full_q, err_q;
  data_t data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (take_i) full_q <= 1'b0;
      if (wr_en_i) begin
        if (full_q) err_q <= 1'b1;
        else begin
          full_q <= 1'b1;
          data_q <= wr_data_i;
        end
      end
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
  assign err_o  = err_q;

  assert_take_when_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_q);
  assert_err_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && full_q) |=> err_q);
  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  assert_full_write_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && full_q) |=> $stable(data_q));
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
  import spi_tx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lead_i,
  input  logic  mid_i,
  input  logic  full_i,
  input  data_t buf_data_i,
  input  logic  cpol_i,
  input  logic  cpha_i,
  output logic  take_o,
  output logic  busy_o,
  output logic  sck_o,
  output logic  mosi_o
);
  logic             active_q, first_q;
  logic [BIT_W-1:0] bit_q;
  data_t            sh_q;
  logic             last;

  assign last   = (bit_q == BIT_W'(DATA_W - 1));
  assign take_o = lead_i && full_i && (!active_q || last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      first_q  <= 1'b0;
      bit_q    <= '0;
      sh_q     <= '0;
    end else if (lead_i) begin
      first_q <= 1'b1;
      if (!active_q || last) begin
        if (full_i) begin
          sh_q     <= buf_data_i;
          active_q <= 1'b1;
          bit_q    <= '0;
        end else begin
          active_q <= 1'b0;
        end
      end else begin
        bit_q <= bit_q + BIT_W'(1);
        sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
      end
    end else if (mid_i) begin
      first_q <= 1'b0;
    end
  end

  // cpha=0: idle level in first half; cpha=1: active level in first half
  assign sck_o  = active_q ? (cpol_i ^ (cpha_i ? first_q : !first_q)) : cpol_i;
  assign mosi_o = active_q ? sh_q[DATA_W-1] : 1'b0;
  assign busy_o = active_q;

  assert_start_on_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(lead_i));
  assert_mosi_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q) && !$past(lead_i)) |-> $stable(mosi_o));
  assert_back_to_back_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_i && active_q && last && full_i) |=> active_q);
  assert_idle_sck_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(active_q) && !active_q) |-> (!mosi_o));
endmodule

// File: rtl/spi_tx_master.sv
module spi_tx_master
  import spi_tx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic                 cpol_i,
  input  logic                 cpha_i,
  input  logic                 wr_en_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic                 tx_empty_o,
  output logic                 wr_err_o,
  output logic                 busy_o,
  output logic                 sck_o,
  output logic                 mosi_o
);
  logic  lead, mid, take, full;
  data_t buf_data;

  spi_tx_clkdiv u_clkdiv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_sel_i (div_sel_i),
    .lead_o    (lead),
    .mid_o     (mid)
  );

  spi_tx_buf u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .full_o    (full),
    .data_o    (buf_data),
    .err_o     (wr_err_o)
  );

  spi_tx_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lead_i     (lead),
    .mid_i      (mid),
    .full_i     (full),
    .buf_data_i (buf_data),
    .cpol_i     (cpol_i),
    .cpha_i     (cpha_i),
    .take_o     (take),
    .busy_o     (busy_o),
    .sck_o      (sck_o),
    .mosi_o     (mosi_o)
  );

  assign tx_empty_o = !full;

  assert_empty_after_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && tx_empty_o) |=> !tx_empty_o);
endmodule

// File: tb/spi_tx_master_bench.sv
`timescale 1ns/1ps
module spi_tx_master_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic       cpol = 1'b0, cpha = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tx_empty, wr_err, busy, sck, mosi;

  int n_tests = 0, n_fail = 0, cycles = 0;

  always #2.5 clk = ~clk;

  spi_tx_master u_spi_tx_master (
    .clk_i(clk), .rst_ni(rst_n), .div_sel_i(div_sel), .cpol_i(cpol), .cpha_i(cpha),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .tx_empty_o(tx_empty), .wr_err_o(wr_err),
    .busy_o(busy), .sck_o(sck), .mosi_o(mosi)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase since reset, held-byte queue, current byte
  int   m_phase, m_bitn;
  bit   m_active, m_first, m_err;
  byte  m_hold[$];
  byte  m_cur;
  byte  exp_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_active = 0; m_first = 0; m_err = 0; m_bitn = 0;
      m_hold.delete();
    end else begin
      int  ratio;
      bit  had_hold, at_lead, at_mid;
      ratio    = 2 << (2 * div_sel);
      had_hold = (m_hold.size() != 0);
      at_lead  = (m_phase == ratio - 1);
      at_mid   = (m_phase == ratio / 2 - 1);
      m_phase  = (m_phase >= ratio - 1) ? 0 : m_phase + 1;
      if (at_lead) begin
        m_first = 1;
        if (!m_active || m_bitn == 7) begin
          if (had_hold) begin
            m_cur = m_hold.pop_front(); m_active = 1; m_bitn = 0;
          end else m_active = 0;
        end else begin
          m_bitn++; m_cur = m_cur << 1;
        end
      end else if (at_mid) m_first = 0;
      if (wr_en) begin
        if (had_hold) m_err = 1;
        else begin m_hold.push_back(wr_data); exp_q.push_back(wr_data); end
      end
    end
  end

  // cycle compare of every output against the model
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_sck, e_mosi;
      e_sck  = m_active ? (cpol ^ (cpha ? m_first : !m_first)) : cpol;
      e_mosi = m_active ? m_cur[7] : 1'b0;
      check(sck == e_sck, "R1 sck", sck, e_sck);
      check(mosi == e_mosi, "R3 mosi", mosi, e_mosi);
      check(busy == m_active, "R7 busy", busy, m_active);
      check(tx_empty == (m_hold.size() == 0), "R6 tx_empty", tx_empty, m_hold.size() == 0);
      check(wr_err == m_err, "R8 wr_err", wr_err, m_err);
    end
  end

  // receiver decode at the ports (R4/R5 sampling edge choice)
  bit   prev_sck = 1'b0;
  int   edge_idx = 0, rx_n = 0;
  byte  rx_byte;
  always @(negedge clk) begin
    if (!rst_n || !busy) begin
      edge_idx = 0; rx_n = 0;
    end else if (sck != prev_sck) begin
      if ((edge_idx % 2) == cpha) begin
        rx_byte = {rx_byte[6:0], mosi};
        rx_n++;
        if (rx_n == 8) begin
          byte e;
          e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'hxx;
          check(rx_byte == e, cpha ? "R5 received byte" : "R4 received byte", rx_byte, e);
          rx_n = 0;
        end
      end
      edge_idx++;
    end
    prev_sck = sck;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic put(input byte b);
    @(negedge clk); #1; wr_en = 1'b1; wr_data = b;
    @(negedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy || !tx_empty) @(negedge clk);
    repeat (3) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0, "R10 busy", busy, 0);
    check(tx_empty == 1, "R10 tx_empty", tx_empty, 1);
    check(wr_err == 0, "R10 wr_err", wr_err, 0);
    check(mosi == 0, "R10 mosi", mosi, 0);
    check(sck == cpol, "R10 sck", sck, cpol);
    #1 rst_n = 1'b1;
    for (int cfg = 0; cfg < 8; cfg++) begin
      int n, ratio;
      div_sel = 2'(cfg / 2);
      cpha    = cfg[0];
      cpol    = cfg[0] ^ cfg[1];
      ratio   = 2 << (2 * div_sel);
      repeat (cfg + 1) @(negedge clk);
      #1;
      put(8'hA5 ^ 8'(cfg * 37));
      n = 1;
      while (!busy) begin @(negedge clk); n++; end
      check(n >= 2 && n <= ratio + 1, "R2 start delay", n - 1, ratio);
      #1;
      while (!tx_empty) begin @(negedge clk); #1; end
      put(8'h3C + 8'(cfg));
      check(tx_empty == 0, "R6 held after write", tx_empty, 0);
      put(8'hFF);  // buffer full: must be discarded
      check(wr_err == 1, "R8 err after full write", wr_err, 1);
      wait_idle();
      check(sck == cpol, "R9 idle sck", sck, cpol);
      check(mosi == 0, "R9 idle mosi", mosi, 0);
      check(exp_q.size() == 0, "R7 all bytes received", exp_q.size(), 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule